// File: doc/BRIEF.md
# Delayed-Coincidence Trigger Controller

This block is the decision logic of a three-detector trigger. It watches three single-bit detector lines, called A, B and C here. A start event is a coincidence of A and B while C is quiet, because C acts as a veto. Once a start event is seen, the block blanks all detector activity for a fixed holdoff so that afterpulses and ringing from the first hit cannot count. It then opens a bounded search window. A hit on B or C inside that window produces a single-clock trigger pulse. If the window runs out with no hit, the block quietly re-arms.

Every detector line first passes through a two-flop synchronizer. A four-state controller sequences idle, holdoff, search and fire, using the 2-bit state codes 00, 01, 10 and 11 in that order. The controller starts two down-counting timers, one for the holdoff and one for the window. Their lengths are derived from the clock frequency and two durations given in nanoseconds. The defaults are 100 MHz, 500 ns and 15 µs, which give 50 and 1500 cycles.

Top module: `coinc_trigger`

## Requirements
- R1: A synchronous active-high reset returns the controller to idle, clears both timers and holds `trig_o` low. A sequence that is under way when reset is applied produces no trigger afterwards.
- R2: Only A=1, B=1, C=0 (after synchronization) starts a sequence from idle. A pattern with C=1 (vetoed), or with A or B low, leaves the block idle, and a later B or C hit then produces no trigger.
- R3: Each detector line reaches the controller through exactly two register stages. A start pattern presented before clock edge n moves the controller into holdoff on edge n+2.
- R4: The holdoff lasts HOLD = (CLK_HZ/10^6)·HOLD_NS/1000 cycles. Detector activity during the holdoff has no effect. For a single-cycle hit presented before edge n+k, no trigger results for k ≤ HOLD.
- R5: The search window lasts WIN = (CLK_HZ/10^6)·WIN_NS/1000 cycles. A B-only or C-only hit presented before edge n+k, with HOLD+1 ≤ k ≤ HOLD+WIN, gives exactly one trigger pulse, high in the cycle after edge n+k+2.
- R6: When the window expires with no hit, the block returns to idle. A hit with k > HOLD+WIN produces no trigger.
- R7: A hit in the window's last cycle, which coincides with expiry (k = HOLD+WIN), still triggers.
- R8: The trigger pulse is one cycle wide even if the hit line stays high. The block then returns to idle, and a held B or C alone does not re-arm it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| det_a | input | 1 | Detector line A, asynchronous |
| det_b | input | 1 | Detector line B, asynchronous |
| det_c | input | 1 | Detector line C, veto and second-stage, asynchronous |
| trig_o | output | 1 | One-cycle trigger pulse, registered |

## Verification
All timing is measured from the edge n before which the start pattern is presented. The holdoff is entered on edge n+2. The window covers the cycles reached by hits presented before edges n+HOLD+1 to n+HOLD+WIN, and a trigger from a hit before edge n+k is high in the cycle after edge n+k+2. The bench sweeps the hit offset k across every cycle from just after the start to past the window's end. It drives inputs on falling edges and records the edge number of each trigger pulse, also on falling edges, so every comparison is against that arithmetic expectation, made half a cycle after the edge on which the output changes.

// File: rtl/coinc_pkg.sv
package coinc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_HOLD   = 2'b01,
        ST_SEARCH = 2'b10,
        ST_FIRE   = 2'b11
    } state_e;

    typedef struct packed {
        state_e st;
        logic   fire;
    } ctrl_regs_t;

    function automatic int unsigned ns_to_cycles(input int unsigned clk_hz, input int unsigned dur_ns);
        return ((clk_hz / 1000000) * dur_ns) / 1000;
    endfunction

endpackage

// File: rtl/coinc_sync.sv
module coinc_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_d, meta_q;
    logic [W-1:0] sync_d, sync_q;

    always_comb begin
        meta_d = raw_i;
        sync_d = meta_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= meta_d;
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q;

    // R3: the synchronized value equals the raw input from two cycles earlier
    assert_sync_delay_R3: assert property (@(posedge clk)
        (!rst && !$past(rst) && !$past(rst, 2)) |-> (sync_o == $past(raw_i, 2)));

endmodule

// File: rtl/coinc_timer.sv
module coinc_timer #(
    parameter int LEN = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = LAST;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = run_i && (cnt_q == '0);

    // R4 (holdoff instance) and R5 (window instance): one step down per running cycle
    assert_timer_step_R4: assert property (@(posedge clk) disable iff (rst)
        (run_i && !load_i && (cnt_q != '0)) |=> (cnt_q == CW'($past(cnt_q) - 1'b1)));

    // R5: a freshly loaded timer starts at its full length
    assert_timer_load_R5: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q == LAST));

endmodule

// File: rtl/coinc_ctrl.sv
module coinc_ctrl
    import coinc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic coinc_i,
    input  logic hit_i,
    input  logic hold_done_i,
    input  logic win_done_i,
    output logic hold_load_o,
    output logic hold_run_o,
    output logic win_load_o,
    output logic win_run_o,
    output logic fire_o
);
    ctrl_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE:   if (coinc_i) r_d.st = ST_HOLD;
            ST_HOLD:   if (hold_done_i) r_d.st = ST_SEARCH;
            ST_SEARCH: begin
                if (hit_i)           r_d.st = ST_FIRE;
                else if (win_done_i) r_d.st = ST_IDLE;
            end
            ST_FIRE:   r_d.st = ST_IDLE;
            default:   r_d.st = ST_IDLE;
        endcase
        r_d.fire = (r_d.st == ST_FIRE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st   <= ST_IDLE;
            r_q.fire <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hold_load_o = (r_q.st == ST_IDLE) && coinc_i;
    assign hold_run_o  = (r_q.st == ST_HOLD);
    assign win_load_o  = (r_q.st == ST_HOLD) && hold_done_i;
    assign win_run_o   = (r_q.st == ST_SEARCH);
    assign fire_o      = r_q.fire;

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> ((r_q.st == ST_IDLE) && !fire_o));

    assert_arm_gate_R2: assert property (@(posedge clk) disable iff (rst)
        ((r_q.st == ST_IDLE) && !coinc_i) |=> (r_q.st == ST_IDLE));

    assert_hold_blind_R4: assert property (@(posedge clk) disable iff (rst)
        ((r_q.st == ST_HOLD) && !hold_done_i) |=> (r_q.st == ST_HOLD));

    assert_expire_idle_R6: assert property (@(posedge clk) disable iff (rst)
        ((r_q.st == ST_SEARCH) && win_done_i && !hit_i) |=> (r_q.st == ST_IDLE));

    assert_hit_wins_R7: assert property (@(posedge clk) disable iff (rst)
        ((r_q.st == ST_SEARCH) && hit_i) |=> fire_o);

    assert_fire_single_R8: assert property (@(posedge clk) disable iff (rst)
        fire_o |=> !fire_o);

    assert_fire_from_search_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(fire_o) |-> ($past(r_q.st) == ST_SEARCH));

endmodule

// File: rtl/coinc_trigger.sv
module coinc_trigger
    import coinc_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 100000000,
    parameter int unsigned HOLD_NS = 500,
    parameter int unsigned WIN_NS  = 15000
) (
    input  logic clk,
    input  logic rst,
    input  logic det_a,
    input  logic det_b,
    input  logic det_c,
    output logic trig_o
);
    localparam int HOLD_CYC = int'(ns_to_cycles(CLK_HZ, HOLD_NS));
    localparam int WIN_CYC  = int'(ns_to_cycles(CLK_HZ, WIN_NS));

    logic [2:0] det_s;
    logic       coinc, hit;
    logic       hold_load, hold_run, hold_done;
    logic       win_load, win_run, win_done;

    coinc_sync #(.W(3)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  ({det_c, det_b, det_a}),
        .sync_o (det_s)
    );

    assign coinc = det_s[0] & det_s[1] & ~det_s[2];
    assign hit   = det_s[1] | det_s[2];

    coinc_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .coinc_i     (coinc),
        .hit_i       (hit),
        .hold_done_i (hold_done),
        .win_done_i  (win_done),
        .hold_load_o (hold_load),
        .hold_run_o  (hold_run),
        .win_load_o  (win_load),
        .win_run_o   (win_run),
        .fire_o      (trig_o)
    );

    coinc_timer #(.LEN(HOLD_CYC)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .load_i (hold_load),
        .run_i  (hold_run),
        .done_o (hold_done)
    );

    coinc_timer #(.LEN(WIN_CYC)) u_win (
        .clk    (clk),
        .rst    (rst),
        .load_i (win_load),
        .run_i  (win_run),
        .done_o (win_done)
    );

endmodule

// File: tb/coinc_trigger_bench.sv
module coinc_trigger_bench;
    localparam int unsigned CLK_HZ = 10000000;
    localparam int H = ((CLK_HZ / 1000000) * 500) / 1000;
    localparam int W = ((CLK_HZ / 1000000) * 15000) / 1000;
    localparam int L = H + W + 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic det_a = 1'b0, det_b = 1'b0, det_c = 1'b0;
    logic trig_o;

    int edge_cnt = 0;
    int pulses = 0;
    int last_edge = -1;
    int checks = 0;
    int fails = 0;

    coinc_trigger #(.CLK_HZ(CLK_HZ), .HOLD_NS(500), .WIN_NS(15000)) u_coinc_trigger (
        .clk(clk), .rst(rst), .det_a(det_a), .det_b(det_b), .det_c(det_c), .trig_o(trig_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    always @(negedge clk) begin
        if (trig_o === 1'b1) begin
            pulses    = pulses + 1;
            last_edge = edge_cnt;
        end
    end

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (edge_cnt > 150000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: actual edge %0d expected below 150000", edge_cnt);
            summary();
        end
    end

    task automatic check(input string req, input int act_p, input int exp_p,
                         input int act_e, input int exp_e);
        checks = checks + 1;
        if (act_p != exp_p || (exp_p > 0 && act_e != exp_e)) begin
            fails = fails + 1;
            $display("FAIL %s: actual pulses=%0d edge=%0d expected pulses=%0d edge=%0d",
                     req, act_p, act_e, exp_p, exp_e);
        end
    endtask

    // start pattern at t=0, hit line held for t in [h_lo,h_hi], hit on B or C,
    // optional reset during t in [r_t, r_t+1]
    task automatic trial(input string req, input logic sa, input logic sb, input logic sc,
                         input int h_lo, input int h_hi, input bit use_c, input int r_t,
                         input int exp_p, input int exp_k);
        int n;
        @(negedge clk);
        pulses    = 0;
        last_edge = -1;
        n = edge_cnt + 1;
        for (int t = 0; t <= L; t++) begin
            if (t > 0) @(negedge clk);
            det_a = (t == 0) ? sa : 1'b0;
            det_b = (t == 0) ? sb : (!use_c && t >= h_lo && t <= h_hi);
            det_c = (t == 0) ? sc : ( use_c && t >= h_lo && t <= h_hi);
            rst   = (r_t >= 0 && t >= r_t && t <= r_t + 1);
        end
        @(negedge clk);
        det_a = 1'b0; det_b = 1'b0; det_c = 1'b0; rst = 1'b0;
        repeat (3) @(negedge clk);
        check(req, pulses, exp_p, last_edge, n + exp_k + 2);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        checks = checks + 1;
        if (trig_o !== 1'b0) begin
            fails = fails + 1;
            $display("FAIL R1 reset state: actual trig=%b expected 0", trig_o);
        end
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R3 R4 R5 R6 R7: sweep single-cycle hit offset across holdoff, window and beyond
        for (int k = 1; k <= H + W + 3; k++) begin
            bit inwin;
            inwin = (k >= H + 1) && (k <= H + W);
            if (k == H + W)
                trial("R7 hit at expiry", 1, 1, 0, k, k, k[0], -1, 1, k);
            else if (k <= H)
                trial("R4 holdoff blind", 1, 1, 0, k, k, k[0], -1, 0, k);
            else if (!inwin)
                trial("R6 late hit", 1, 1, 0, k, k, k[0], -1, 0, k);
            else if (k == H + 1)
                trial("R3 first window cycle", 1, 1, 0, k, k, k[0], -1, 1, k);
            else
                trial("R5 window hit", 1, 1, 0, k, k, k[0], -1, 1, k);
        end

        // R2: veto and incomplete coincidences do not arm
        trial("R2 veto C", 1, 1, 1, H + 10, H + 10, 1, -1, 0, 0);
        trial("R2 A only", 1, 0, 0, H + 10, H + 10, 1, -1, 0, 0);
        trial("R2 B only", 0, 1, 0, H + 10, H + 10, 0, -1, 0, 0);
        trial("R2 B and C", 0, 1, 1, H + 10, H + 10, 1, -1, 0, 0);

        // R8: held hit gives one pulse and does not re-arm
        trial("R8 held C", 1, 1, 0, H + 2, H + 40, 1, -1, 1, H + 2);
        trial("R8 held B", 1, 1, 0, H + 3, H + 60, 0, -1, 1, H + 3);
        trial("R8 rearm after hold", 1, 1, 0, H + 7, H + 7, 1, -1, 1, H + 7);

        // R1: reset in holdoff or window kills the sequence
        trial("R1 reset in holdoff", 1, 1, 0, H + 5, H + 5, 1, 3, 0, 0);
        trial("R1 reset in window", 1, 1, 0, H + 30, H + 30, 1, H + 10, 0, 0);
        trial("R1 normal after reset", 1, 1, 0, H + 20, H + 20, 0, -1, 1, H + 20);

        summary();
    end

endmodule